// File: doc/BRIEF.md
# Host Bridge DMA Window Register Bank

This block is the register bank of a PCI host bridge. It holds four DMA windows and one bridge control register. Each window has a base register, a mask register and a translated-base register. All registers are 64 bits wide. Software reaches the bank through a single-cycle request port. Each request carries a byte offset, byte enables, a write flag and write data. Exactly one cycle later the bank answers with a response that carries read data and an error flag.

The contents of the window registers and the control register are driven out in parallel to a separate address translation unit. The bank also decodes a fixed group of auxiliary indices. These cover error status and mask, error set, two TLB invalidate variants, a latency register, a reserved slot and two monitor registers. Each of these has a fixed behaviour: it reads as zero, it drops its write data, or it is refused. Any access the bank cannot serve raises the error flag and changes nothing.

Top module: `hb_win_regs`

## Requirements
- R1: While reset is asserted and after it, every window output and every window register read returns zero, and the control register holds 0x0000_0021_0010_0000 (bits 20, 32 and 37 set).
- R2: The register index is req_addr_i bits [11:6]; bits [5:3] do not affect decode. Window w (0..3) uses index 4w for base, 4w+1 for mask and 4w+2 for translated base. Index 16 is the control register.
- R3: Window and control registers store all 64 written bits. A write shows on ctrl_o or on window slice w, bits [64w+63:64w] of win_base_o, win_mask_o or win_xlat_o, starting the cycle after the request. A later read returns the stored value. No output changes without an accepted write.
- R4: Every request cycle gets exactly one response, with rsp_valid_o high, in the following cycle. No response appears in any other cycle.
- R5: Only full 64-bit accesses are legal. If req_be_i is not 8'hFF, or req_addr_i[2:0] is not zero, the access is refused with rsp_err_o.
- R6: Index 17 (error status) reads as zero without error. A write to it is accepted without error and has no effect.
- R7: Index 18 (error mask) reads as zero without error. A write to it is refused with rsp_err_o.
- R8: Index 20 (invalidate all TLB entries) reads as zero without error. A write to it is accepted without error and its data is discarded.
- R9: Index 4w+3, indices 19 and 21 to 25 (error set, single-entry invalidate, latency, reserved, monitor control, monitor count), and every index of 26 or above are refused with rsp_err_o on both read and write.
- R10: A refused access returns zero read data and leaves every register unchanged.
- R11: A write response carries zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset into the bank |
| req_be_i | input | 8 | Byte enables |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response present this cycle |
| rsp_err_o | output | 1 | Access refused |
| rsp_rdata_o | output | 64 | Read data |
| ctrl_o | output | 64 | Bridge control register |
| win_base_o | output | 256 | Window base registers, window w in bits [64w+63:64w] |
| win_mask_o | output | 256 | Window mask registers, same packing |
| win_xlat_o | output | 256 | Translated-base registers, same packing |

## Verification
Every response, whether read data, error flag or the absence of a response, is due exactly one clock edge after its request. Register outputs move at that same edge. The driver stamps each expected item with the edge at which it falls due. The monitor samples on the falling edge and flags a response that is early, late, missing or not expected. Port snapshots of all window and control outputs are taken only after idle cycles, so each refused or dropped write is shown to have left the state untouched before the next write arrives.

// File: rtl/hb_win_pkg.sv
package hb_win_pkg;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned BE_W   = REG_W / 8;
  localparam int unsigned FLD_N  = 4;   // index slots per window

  // offsets of the auxiliary registers past the last window slot
  localparam int unsigned OFS_CTRL     = 0;
  localparam int unsigned OFS_ERR_STAT = 1;
  localparam int unsigned OFS_ERR_MASK = 2;
  localparam int unsigned OFS_ERR_SET  = 3;
  localparam int unsigned OFS_TLB_ALL  = 4;
  localparam int unsigned OFS_TLB_ONE  = 5;
  localparam int unsigned OFS_LAT      = 6;
  localparam int unsigned OFS_RSVD     = 7;
  localparam int unsigned OFS_MON_CTL  = 8;
  localparam int unsigned OFS_MON_CNT  = 9;

  localparam logic [REG_W-1:0] CTRL_RST =
    (REG_W'(1) << 20) | (REG_W'(1) << 32) | (REG_W'(1) << 37);

  typedef enum logic [2:0] {
    ACC_WIN,       // window register
    ACC_CTRL,      // control register
    ACC_RZ_WDROP,  // reads zero, write dropped
    ACC_RZ_WBAD,   // reads zero, write refused
    ACC_BAD        // refused either way
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_XLAT = 2'd2,
    FLD_NONE = 2'd3
  } win_fld_e;

  typedef struct packed {
    acc_kind_e kind;
    win_fld_e  fld;
  } acc_dec_t;
endpackage

// File: rtl/hb_win_decode.sv
module hb_win_decode
  import hb_win_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned IDX_W    = ADDR_W - 6,
  localparam int unsigned WSEL_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int unsigned WIN_SPAN = NUM_WIN * FLD_N
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              aligned_i,
  input  logic              write_i,
  output acc_dec_t          dec_o,
  output logic [WSEL_W-1:0] win_o,
  output logic              err_o
);
  logic [IDX_W-1:0] rel;
  logic             in_win;

  assign rel    = idx_i - IDX_W'(WIN_SPAN);
  assign in_win = idx_i < IDX_W'(WIN_SPAN);

  always_comb begin
    dec_o = '{kind: ACC_BAD, fld: FLD_NONE};
    win_o = '0;
    if (in_win) begin
      win_o     = WSEL_W'(idx_i >> 2);
      dec_o.fld = win_fld_e'(idx_i[1:0]);
      dec_o.kind = (idx_i[1:0] == 2'd3) ? ACC_BAD : ACC_WIN;
    end else begin
      case (rel)
        IDX_W'(OFS_CTRL):     dec_o.kind = ACC_CTRL;
        IDX_W'(OFS_ERR_STAT): dec_o.kind = ACC_RZ_WDROP;
        IDX_W'(OFS_ERR_MASK): dec_o.kind = ACC_RZ_WBAD;
        IDX_W'(OFS_TLB_ALL):  dec_o.kind = ACC_RZ_WDROP;
        IDX_W'(OFS_ERR_SET),
        IDX_W'(OFS_TLB_ONE),
        IDX_W'(OFS_LAT),
        IDX_W'(OFS_RSVD),
        IDX_W'(OFS_MON_CTL),
        IDX_W'(OFS_MON_CNT):  dec_o.kind = ACC_BAD;
        default:              dec_o.kind = ACC_BAD;
      endcase
    end
  end

  assign err_o = !aligned_i
              || (dec_o.kind == ACC_BAD)
              || (dec_o.kind == ACC_RZ_WBAD && write_i);
endmodule

// File: rtl/hb_win_slot.sv
module hb_win_slot
  import hb_win_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  win_fld_e         fld_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] base_o,
  output logic [REG_W-1:0] mask_o,
  output logic [REG_W-1:0] xlat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      mask_o <= '0;
      xlat_o <= '0;
    end else if (we_i) begin
      case (fld_i)
        FLD_BASE: base_o <= wdata_i;
        FLD_MASK: mask_o <= wdata_i;
        FLD_XLAT: xlat_o <= wdata_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/hb_win_ctrl.sv
module hb_win_ctrl
  import hb_win_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = CTRL_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= RST_VAL;
    else if (we_i) ctrl_o <= wdata_i;
  end
endmodule

// File: rtl/hb_win_regs.sv
module hb_win_regs
  import hb_win_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic                     req_write_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [BE_W-1:0]          req_be_i,
  input  logic [REG_W-1:0]         req_wdata_i,
  output logic                     rsp_valid_o,
  output logic                     rsp_err_o,
  output logic [REG_W-1:0]         rsp_rdata_o,
  output logic [REG_W-1:0]         ctrl_o,
  output logic [NUM_WIN*REG_W-1:0] win_base_o,
  output logic [NUM_WIN*REG_W-1:0] win_mask_o,
  output logic [NUM_WIN*REG_W-1:0] win_xlat_o
);
  localparam int unsigned IDX_W  = ADDR_W - 6;
  localparam int unsigned WSEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  acc_dec_t          dec;
  logic [WSEL_W-1:0] win_sel;
  logic              dec_err;
  logic              aligned;
  logic              wr_ok;
  logic              rd_ok;
  logic [REG_W-1:0]  rd_mux;
  logic [REG_W-1:0]  base_w [NUM_WIN];
  logic [REG_W-1:0]  mask_w [NUM_WIN];
  logic [REG_W-1:0]  xlat_w [NUM_WIN];
  logic              unused_addr_bits;

  // bits [5:3] select a byte lane group inside the 64-byte stride only
  assign unused_addr_bits = ^req_addr_i[5:3];
  assign aligned = (req_addr_i[2:0] == 3'd0) && (&req_be_i);

  hb_win_decode #(
    .NUM_WIN (NUM_WIN),
    .ADDR_W  (ADDR_W)
  ) i_decode (
    .idx_i     (req_addr_i[ADDR_W-1:6]),
    .aligned_i (aligned),
    .write_i   (req_write_i),
    .dec_o     (dec),
    .win_o     (win_sel),
    .err_o     (dec_err)
  );

  assign wr_ok = req_valid_i &&  req_write_i && !dec_err;
  assign rd_ok = req_valid_i && !req_write_i && !dec_err;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic we;
    assign we = wr_ok && (dec.kind == ACC_WIN) && (win_sel == WSEL_W'(w));

    hb_win_slot i_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .fld_i   (dec.fld),
      .wdata_i (req_wdata_i),
      .base_o  (base_w[w]),
      .mask_o  (mask_w[w]),
      .xlat_o  (xlat_w[w])
    );

    assign win_base_o[w*REG_W +: REG_W] = base_w[w];
    assign win_mask_o[w*REG_W +: REG_W] = mask_w[w];
    assign win_xlat_o[w*REG_W +: REG_W] = xlat_w[w];
  end

  hb_win_ctrl #(
    .RST_VAL (CTRL_RST)
  ) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok && dec.kind == ACC_CTRL),
    .wdata_i (req_wdata_i),
    .ctrl_o  (ctrl_o)
  );

  always_comb begin
    rd_mux = '0;
    case (dec.kind)
      ACC_WIN: begin
        case (dec.fld)
          FLD_BASE: rd_mux = base_w[win_sel];
          FLD_MASK: rd_mux = mask_w[win_sel];
          FLD_XLAT: rd_mux = xlat_w[win_sel];
          default:  rd_mux = '0;
        endcase
      end
      ACC_CTRL: rd_mux = ctrl_o;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && dec_err;
      rsp_rdata_o <= rd_ok ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/hb_win_regs_chk.sv
module hb_win_regs_chk
  import hb_win_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic                     req_write_i,
  input logic [BE_W-1:0]          req_be_i,
  input logic                     rsp_valid_o,
  input logic                     rsp_err_o,
  input logic [REG_W-1:0]         rsp_rdata_o,
  input logic [REG_W-1:0]         ctrl_o,
  input logic [NUM_WIN*REG_W-1:0] win_base_o,
  input logic [NUM_WIN*REG_W-1:0] win_mask_o,
  input logic [NUM_WIN*REG_W-1:0] win_xlat_o
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R4
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R4
  AST_PARTIAL_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !(&req_be_i)) |=> rsp_err_o); // R5
  AST_ERR_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && rsp_rdata_o == '0)); // R10
  AST_WRITE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> (rsp_rdata_o == '0)); // R11
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_write_i) |=>
      ($stable(ctrl_o) && $stable(win_base_o) &&
       $stable(win_mask_o) && $stable(win_xlat_o))); // R3
  AST_REFUSED_NO_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !(&req_be_i)) |=>
      ($stable(ctrl_o) && $stable(win_base_o) &&
       $stable(win_mask_o) && $stable(win_xlat_o))); // R10
endmodule

bind hb_win_regs hb_win_regs_chk #(.NUM_WIN(NUM_WIN)) i_hb_win_regs_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_be_i    (req_be_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_rdata_o (rsp_rdata_o),
  .ctrl_o      (ctrl_o),
  .win_base_o  (win_base_o),
  .win_mask_o  (win_mask_o),
  .win_xlat_o  (win_xlat_o)
);

// File: tb/test_hb_win_regs.sv
`timescale 1ns/1ps
module test_hb_win_regs;
  localparam int NW = 4;
  localparam int AW = 12;
  localparam logic [63:0] CTRL_INIT = 64'h0000_0021_0010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic [AW-1:0]  req_addr  = '0;
  logic [7:0]     req_be    = '0;
  logic [63:0]    req_wdata = '0;
  logic           rsp_valid;
  logic           rsp_err;
  logic [63:0]    rsp_rdata;
  logic [63:0]    ctrl;
  logic [NW*64-1:0] wbase, wmask, wxlat;

  hb_win_regs i_hb_win_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .ctrl_o(ctrl), .win_base_o(wbase), .win_mask_o(wmask), .win_xlat_o(wxlat)
  );

  typedef struct {
    int          due;
    logic        err;
    logic [63:0] rdata;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          fails  = 0;
  int          edge_cnt = 0;
  int          n_req = 0;
  int          n_rsp = 0;
  bit          done = 0;
  logic [63:0] m_base[NW], m_mask[NW], m_xlat[NW], m_ctrl;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        n_rsp++;
        if (q.size() == 0 || q[0].due != edge_cnt) begin
          chk("R4 unexpected response", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " err"}, 64'(rsp_err), 64'(e.err));
          chk({e.tag, " rdata"}, rsp_rdata, e.rdata);
        end
      end else if (q.size() != 0 && q[0].due <= edge_cnt) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " R4 missing response"}, 64'd0, 64'd1);
      end
    end
  end

  task automatic access(bit wr, logic [AW-1:0] a, logic [7:0] be,
                        logic [63:0] d, string tag);
    int          idx;
    bit          bad;
    logic [63:0] rd;
    idx = int'(a >> 6);
    rd  = '0;
    bad = (a[2:0] != 3'd0) || (be != 8'hFF);
    if (idx < 16) begin
      if (idx % 4 == 3) bad = 1;
    end else if (idx == 16 || idx == 17 || idx == 20) begin
    end else if (idx == 18) begin
      if (wr) bad = 1;
    end else bad = 1;
    if (!bad) begin
      if (idx < 16) begin
        case (idx % 4)
          0: if (wr) m_base[idx/4] = d; else rd = m_base[idx/4];
          1: if (wr) m_mask[idx/4] = d; else rd = m_mask[idx/4];
          default: if (wr) m_xlat[idx/4] = d; else rd = m_xlat[idx/4];
        endcase
      end else if (idx == 16) begin
        if (wr) m_ctrl = d; else rd = m_ctrl;
      end
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_be    = be;
    req_wdata = d;
    n_req++;
    q.push_back('{due: edge_cnt + 1, err: bad, rdata: (wr || bad) ? 64'd0 : rd, tag: tag});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic check_ports(string tag);
    chk({tag, " ctrl_o"}, ctrl, m_ctrl);
    for (int w = 0; w < NW; w++) begin
      chk({tag, " base"}, wbase[w*64 +: 64], m_base[w]);
      chk({tag, " mask"}, wmask[w*64 +: 64], m_mask[w]);
      chk({tag, " xlat"}, wxlat[w*64 +: 64], m_xlat[w]);
    end
  endtask

  function automatic logic [AW-1:0] ra(int idx);
    return AW'(idx << 6);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_base[w] = '0; m_mask[w] = '0; m_xlat[w] = '0;
    end
    m_ctrl = CTRL_INIT;

    #13;
    check_ports("R1 during reset");
    chk("R1 no response in reset", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    check_ports("R1 after reset");

    access(0, ra(16), 8'hFF, 0, "R1 ctrl reset readback");
    access(0, ra(0), 8'hFF, 0, "R1 base0 reset readback");
    access(0, ra(14), 8'hFF, 0, "R1 xlat3 reset readback");

    // back-to-back writes then reads
    for (int w = 0; w < NW; w++) begin
      access(1, ra(4*w),   8'hFF, 64'hA5A5_0000_1111_0000 ^ 64'(w),        "R3 R11 base write");
      access(1, ra(4*w+1), 8'hFF, 64'h0000_FFF0_0000_0000 | 64'(w << 20), "R3 R11 mask write");
      access(1, ra(4*w+2), 8'hFF, 64'hDEAD_BEEF_0000_0000 + 64'(w << 8),  "R3 R11 xlat write");
    end
    for (int w = 0; w < NW; w++) begin
      access(0, ra(4*w),   8'hFF, 0, "R2 R3 base read");
      access(0, ra(4*w+1), 8'hFF, 0, "R2 R3 mask read");
      access(0, ra(4*w+2), 8'hFF, 0, "R2 R3 xlat read");
    end
    idle(2);
    check_ports("R3 window outputs");

    access(1, ra(5) | AW'('h38), 8'hFF, 64'h0123_4567_89AB_CDEF, "R2 offset bits 5:3 ignored write");
    access(0, ra(5), 8'hFF, 0, "R2 offset bits 5:3 read");
    access(0, ra(5) | AW'('h18), 8'hFF, 0, "R2 offset bits 5:3 read alt");

    access(1, ra(16), 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, "R3 ctrl all ones");
    access(0, ra(16), 8'hFF, 0, "R3 ctrl read ones");
    access(1, ra(16), 8'hFF, 64'h0000_0000_0000_1234, "R3 ctrl pattern");
    access(0, ra(16), 8'hFF, 0, "R3 ctrl read pattern");
    idle(2);
    check_ports("R3 ctrl output");

    access(1, ra(8), 8'h0F, 64'h5555_5555_5555_5555, "R5 partial byte enables write");
    access(1, ra(16) | AW'(4), 8'hFF, 64'h7777, "R5 misaligned write");
    access(0, ra(9), 8'hFE, 0, "R5 R10 partial read");
    access(0, ra(16) | AW'(2), 8'hFF, 0, "R5 R10 misaligned read");
    idle(2);
    check_ports("R10 refused writes left state");

    access(0, ra(17), 8'hFF, 0, "R6 error status read");
    access(1, ra(17), 8'hFF, 64'hFFFF_0000_FFFF_0000, "R6 error status write");
    access(0, ra(17), 8'hFF, 0, "R6 error status read after write");
    access(0, ra(18), 8'hFF, 0, "R7 error mask read");
    access(1, ra(18), 8'hFF, 64'h1, "R7 error mask write refused");
    access(0, ra(20), 8'hFF, 0, "R8 tlb flush read");
    access(1, ra(20), 8'hFF, 64'hCAFE, "R8 tlb flush write");
    idle(2);
    check_ports("R6 R8 dropped writes left state");

    begin
      int bad_idx [14] = '{3, 7, 11, 15, 19, 21, 22, 23, 24, 25, 26, 40, 62, 63};
      foreach (bad_idx[i]) begin
        access(0, ra(bad_idx[i]), 8'hFF, 0, "R9 unsupported read");
        access(1, ra(bad_idx[i]), 8'hFF, 64'hBAD0_BAD0_BAD0_BAD0, "R9 R10 unsupported write");
      end
    end
    idle(2);
    check_ports("R9 R10 unsupported writes left state");

    access(1, ra(0), 8'hFF, 64'h1, "R4 burst w");
    access(0, ra(0), 8'hFF, 0, "R4 burst r");
    access(0, ra(63), 8'hFF, 0, "R4 burst err");
    access(0, ra(16), 8'hFF, 0, "R4 burst ctrl");
    idle(4);
    chk("R4 all responses drained", 64'(q.size()), 64'd0);
    chk("R4 response count", 64'(n_rsp), 64'(n_req));

    done = 1;
    summary();
    $finish;
  end
endmodule